// File: doc/BRIEF.md
# Modulo Timer with Break-Protected Flags

A 16-bit up-counter that advances on a prescaled version of the bus clock and returns to zero after it reaches a programmable limit. Each wrap sets an overflow flag. When the matching enable bit is also set, that flag drives an interrupt line. Software works the timer through a small byte-wide register bus. A control/status byte holds the flag, the interrupt enable, a halt bit, a one-shot counter clear bit and a 3-bit divider select. Two bytes read back the live count and two bytes hold the limit.

The overflow flag is cleared in two steps. Software first reads the control/status byte while the flag is 1, which arms the clear. A later write with a 0 in the flag position then clears it. A debug-halt input and a clear-permit bit decide what such accesses may do while a debugger has the system stopped. With the permit bit at 0, software can read and write the registers freely during a halt and the flag does not change. An arm made before the halt is kept, so the write that completes the clear can follow once the halt ends. With the permit bit at 1, a clear made during the halt holds after the halt.

Reading the upper count byte captures the lower byte. The next lower-byte read therefore gives a consistent 16-bit value even while the counter runs.

Top module: `mtmr_top`

## Requirements
- R1: After reset the control/status byte (address 0) reads 0x20, the count reads 0x0000, the limit (address 3 high, 4 low) reads 0xFFFF, the debug byte (address 5) reads 0x00 and irq is 0.
- R2: In the control/status byte, bit 7 is the overflow flag, bit 6 the interrupt enable, bit 5 halt, bit 4 clear and bits 2:0 the divider select. Bit 4 and bit 3 always read 0, and bit 3 ignores writes.
- R3: While halt is 0 with divider select n, the counter advances once every 2^n clocks for n from 0 to 6. The value 7 acts as 6.
- R4: On an advance from a count equal to the limit the count becomes 0x0000. A limit of 0xFFFF gives the full 16-bit count. The count bytes at addresses 1 and 2 are read-only.
- R5: An advance that wraps the count sets the overflow flag. irq is 1 exactly when the flag and the interrupt enable are both 1.
- R6: A control/status write with bit 4 set zeroes the count and the divider on that clock edge. The other fields take the written values.
- R7: While halt is 1, neither the count nor the divider changes.
- R8: A control/status read that sees the flag at 1 arms the clear, and a later control/status write with bit 7 at 0 then clears the flag. A write with bit 7 at 0 that has no arm before it leaves the flag set, and a write with bit 7 at 1 leaves it unchanged.
- R9: If a wrap and a clearing write fall in the same cycle, the flag stays set.
- R10: A read of the high count byte captures the low byte. The next low-byte read returns the captured value, and a low-byte read with no capture pending returns the live low byte.
- R11: With dbg_brk at 1 and the permit bit at 0, control/status reads do not arm and control/status writes do not clear the flag.
- R12: An arm made before a halt survives it. After dbg_brk returns to 0, a write with bit 7 at 0 clears the flag.
- R13: With the permit bit at 1, the two-step clear works during dbg_brk and the flag stays 0 after dbg_brk falls.
- R14: Bit 0 of the debug byte (address 5) is the clear-permit bit. Its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_brk | input | 1 | Debugger halt active |
| bus_sel | input | 1 | Register access select |
| bus_rd | input | 1 | Read strobe (one cycle per access) |
| bus_wr | input | 1 | Write strobe (one cycle per access) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when no read is active |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench targets the flag-clear sequence under every combination of halt and permit bit. These are a write with no arm, a read during a halt followed by a write after it, an arm before a halt, and a clear made under permission. A design that cleared on any zero write, or that armed during a protected halt, would drop the flag where the bench expects it held. The bench also runs a zero limit so that a wrap lands in the same cycle as a clearing write, where the wrong priority would lose an overflow. Further tests cover the captured low byte against a running counter, the clamp of divider select 7 and a full 0xFFFF rollover, where an off-by-one in the divider or the wrap compare would show as a wrong count.

// File: rtl/mtmr_pkg.sv
`timescale 1ns/1ps
// Shared constants for the modulo timer: bus widths, register addresses
// and control/status bit positions. Assumes a byte-wide register bus.
package mtmr_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int SEL_W  = 3;

    localparam logic [ADDR_W-1:0] ADR_CSR  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CNTH = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CNTL = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_LIMH = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_LIML = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_DBG  = 3'd5;

    localparam int BIT_OVF  = 7;
    localparam int BIT_IE   = 6;
    localparam int BIT_HALT = 5;
    localparam int BIT_CLR  = 4;
endpackage

// File: rtl/mtmr_prescaler.sv
`timescale 1ns/1ps
// Clock divider for the timer. It emits a one-cycle tick every 2^n enabled
// clocks, where n is the select value clamped to MAX_EXP.
// Assumes clr and run are synchronous to clk.
module mtmr_prescaler #(
    parameter int SEL_W   = 3,
    parameter int MAX_EXP = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [MAX_EXP-1:0] phase;
    logic [MAX_EXP-1:0] mask;

    // Build a mask of the low bits that must all be 1 for a tick (clamped)
    always_comb begin
        for (int i = 0; i < MAX_EXP; i++) begin
            mask[i] = (i < int'(sel));
        end
    end

    assign tick = run && ((phase & mask) == mask);

    // Divider phase counter: cleared on request, frozen while halted
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (clr)     phase <= '0;
        else if (run)     phase <= phase + 1'b1;
    end
endmodule

// File: rtl/mtmr_counter.sv
`timescale 1ns/1ps
// Wrapping up-counter. It steps on tick and returns to zero after it
// reaches the limit. wrap marks the advance that returns to zero.
// Assumes clr takes priority over tick.
module mtmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic at_limit;

    assign at_limit = (count == limit);
    assign wrap     = tick && !clr && at_limit;

    // Count register: clear, wrap to zero at the limit, or step by one
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (clr)     count <= '0;
        else if (tick)    count <= at_limit ? '0 : count + 1'b1;
    end
endmodule

// File: rtl/mtmr_regs.sv
`timescale 1ns/1ps
// Register bank and flag logic. It decodes the byte bus, holds control,
// limit and debug bits, and runs the two-step overflow clear with halt
// protection and the capture of the low count byte.
// Assumes at most one of bus_rd / bus_wr per cycle.
module mtmr_regs
    import mtmr_pkg::*;
#(
    parameter int              CW         = 2 * DATA_W,
    parameter logic [CW-1:0]   LIMIT_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_brk,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CW-1:0]     count,
    input  logic              wrap,
    output logic              ovf_flag,
    output logic              ctl_ie,
    output logic              ctl_halt,
    output logic [SEL_W-1:0]  ctl_sel,
    output logic              cnt_clr,
    output logic [CW-1:0]     limit,
    output logic              permit
);
    logic acc_rd, acc_wr, csr_rd, csr_wr, guarded, flag_clear;
    logic armed;
    logic cap_vld;
    logic [DATA_W-1:0] cap_byte;
    logic unused_bits;

    assign acc_rd     = bus_sel && bus_rd;
    assign acc_wr     = bus_sel && bus_wr;
    assign csr_rd     = acc_rd && (bus_addr == ADR_CSR);
    assign csr_wr     = acc_wr && (bus_addr == ADR_CSR);
    assign guarded    = dbg_brk && !permit;
    assign cnt_clr    = csr_wr && bus_wdata[BIT_CLR];
    assign flag_clear = csr_wr && !bus_wdata[BIT_OVF] && armed && !guarded;
    assign unused_bits = bus_wdata[3];

    // Control fields: interrupt enable, halt (set at reset), divider select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_ie   <= 1'b0;
            ctl_halt <= 1'b1;
            ctl_sel  <= '0;
        end else if (csr_wr) begin
            ctl_ie   <= bus_wdata[BIT_IE];
            ctl_halt <= bus_wdata[BIT_HALT];
            ctl_sel  <= bus_wdata[SEL_W-1:0];
        end
    end

    // Overflow flag and clear arm: a set from a wrap wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            armed    <= 1'b0;
        end else begin
            if (wrap)            ovf_flag <= 1'b1;
            else if (flag_clear) ovf_flag <= 1'b0;

            if (flag_clear && !wrap)                armed <= 1'b0;
            else if (csr_rd && ovf_flag && !guarded) armed <= 1'b1;
        end
    end

    // Limit register, written a byte at a time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit <= LIMIT_INIT;
        end else if (acc_wr && bus_addr == ADR_LIMH) begin
            limit[CW-1:DATA_W] <= bus_wdata;
        end else if (acc_wr && bus_addr == ADR_LIML) begin
            limit[DATA_W-1:0] <= bus_wdata;
        end
    end

    // Debug byte: clear-permit bit only
    always_ff @(posedge clk) begin
        if (!rst_n)                             permit <= 1'b0;
        else if (acc_wr && bus_addr == ADR_DBG) permit <= bus_wdata[0];
    end

    // Capture the low count byte on a high-byte read, release it on a low read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld  <= 1'b0;
            cap_byte <= '0;
        end else if (acc_rd && bus_addr == ADR_CNTH) begin
            cap_vld  <= 1'b1;
            cap_byte <= count[DATA_W-1:0];
        end else if (acc_rd && bus_addr == ADR_CNTL) begin
            cap_vld  <= 1'b0;
        end
    end

    // Read multiplexer, zero when no read is active
    always_comb begin
        bus_rdata = '0;
        if (acc_rd) begin
            case (bus_addr)
                ADR_CSR:  bus_rdata = {ovf_flag, ctl_ie, ctl_halt, 2'b00, ctl_sel};
                ADR_CNTH: bus_rdata = count[CW-1:DATA_W];
                ADR_CNTL: bus_rdata = cap_vld ? cap_byte : count[DATA_W-1:0];
                ADR_LIMH: bus_rdata = limit[CW-1:DATA_W];
                ADR_LIML: bus_rdata = limit[DATA_W-1:0];
                ADR_DBG:  bus_rdata = {{(DATA_W-1){1'b0}}, permit};
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mtmr_top.sv
`timescale 1ns/1ps
// Modulo timer top: divider, wrapping counter and register bank.
// irq follows the overflow flag gated by the enable.
// Assumes a single clock domain and a synchronous active-low reset.
module mtmr_top
    import mtmr_pkg::*;
#(
    parameter int MAX_EXP = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_brk,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CW = 2 * DATA_W;

    logic             tick, wrap, cnt_clr, ovf_flag, ctl_ie, ctl_halt, permit;
    logic [SEL_W-1:0] ctl_sel;
    logic [CW-1:0]    count, limit;

    mtmr_prescaler #(.SEL_W(SEL_W), .MAX_EXP(MAX_EXP)) u_div (
        .clk(clk), .rst_n(rst_n), .run(!ctl_halt), .clr(cnt_clr),
        .sel(ctl_sel), .tick(tick)
    );

    mtmr_counter #(.W(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(cnt_clr),
        .limit(limit), .count(count), .wrap(wrap)
    );

    mtmr_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .dbg_brk(dbg_brk),
        .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .wrap(wrap), .ovf_flag(ovf_flag), .ctl_ie(ctl_ie),
        .ctl_halt(ctl_halt), .ctl_sel(ctl_sel), .cnt_clr(cnt_clr),
        .limit(limit), .permit(permit)
    );

    assign irq = ovf_flag && ctl_ie;
endmodule

// File: rtl/mtmr_chk.sv
`timescale 1ns/1ps
// Property checker for the modulo timer, attached to every mtmr_top by bind.
// Assumes the internal names ovf_flag, ctl_ie, ctl_halt, count and permit.
module mtmr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        dbg_brk,
    input logic        bus_sel,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic        irq,
    input logic        ovf_flag,
    input logic        ctl_ie,
    input logic        ctl_halt,
    input logic        permit,
    input logic [15:0] count
);
    logic csr_wr, csr_rd;
    assign csr_wr = bus_sel && bus_wr && (bus_addr == 3'd0);
    assign csr_rd = bus_sel && bus_rd && (bus_addr == 3'd0);

    // R2
    csr_pad_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rd |-> (bus_rdata[4:3] == 2'b00));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == $past(count) + 16'd1 || count == 16'd0));

    // R4
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (count == 16'd0));

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($rose(ovf_flag) || $rose(ctl_ie)));

    // R7
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_halt && !(csr_wr && bus_wdata[4])) |=> $stable(count));

    // R8
    clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_flag) |-> $past(csr_wr && !bus_wdata[7]));

    // R11
    halt_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_brk && !permit) |=> !$fell(ovf_flag));
endmodule

bind mtmr_top mtmr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dbg_brk(dbg_brk), .bus_sel(bus_sel),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .ovf_flag(ovf_flag), .ctl_ie(ctl_ie), .ctl_halt(ctl_halt),
    .permit(permit), .count(count)
);

// File: tb/sim_mtmr_top.sv
`timescale 1ns/1ps
module sim_mtmr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dbg_brk = 1'b0;
    logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mtmr_top u0 (
        .clk(clk), .rst_n(rst_n), .dbg_brk(dbg_brk), .bus_sel(bus_sel),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    int m_flag, m_ie, m_halt, m_sel, m_cnt, m_div, m_lim, m_permit, m_arm, m_cv, m_cb;

    function automatic int model_rdata();
        if (!(bus_sel && bus_rd)) return 0;
        case (bus_addr)
            3'd0: return m_flag * 128 + m_ie * 64 + m_halt * 32 + m_sel;
            3'd1: return m_cnt / 256;
            3'd2: return m_cv ? m_cb : m_cnt % 256;
            3'd3: return m_lim / 256;
            3'd4: return m_lim % 256;
            3'd5: return m_permit;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = 0; m_ie = 0; m_halt = 1; m_sel = 0; m_cnt = 0; m_div = 0;
            m_lim = 65535; m_permit = 0; m_arm = 0; m_cv = 0; m_cb = 0;
        end else begin
            int  e, period, nc, nd;
            bit  rdc, wrc, clrw, adv, wrapped, cleared, guard;
            guard   = dbg_brk && (m_permit == 0);
            rdc     = bus_sel && bus_rd && bus_addr == 0;
            wrc     = bus_sel && bus_wr && bus_addr == 0;
            clrw    = wrc && bus_wdata[4];
            e       = (m_sel > 6) ? 6 : m_sel;
            period  = 1 << e;
            adv     = (m_halt == 0) && ((m_div % period) == period - 1);
            wrapped = adv && !clrw && (m_cnt == m_lim);
            nc = m_cnt; nd = m_div;
            if (clrw) begin nc = 0; nd = 0; end
            else begin
                if (adv) nc = (m_cnt == m_lim) ? 0 : (m_cnt + 1) % 65536;
                if (m_halt == 0) nd = (m_div + 1) % 64;
            end
            cleared = wrc && !bus_wdata[7] && m_arm != 0 && !guard;
            if (bus_sel && bus_rd && bus_addr == 1) begin m_cv = 1; m_cb = m_cnt % 256; end
            else if (bus_sel && bus_rd && bus_addr == 2) m_cv = 0;
            if (cleared && !wrapped) m_arm = 0;
            else if (rdc && m_flag != 0 && !guard) m_arm = 1;
            if (wrapped) m_flag = 1;
            else if (cleared) m_flag = 0;
            if (wrc) begin m_ie = bus_wdata[6]; m_halt = bus_wdata[5]; m_sel = bus_wdata[2:0]; end
            if (bus_sel && bus_wr && bus_addr == 3) m_lim = bus_wdata * 256 + m_lim % 256;
            if (bus_sel && bus_wr && bus_addr == 4) m_lim = (m_lim / 256) * 256 + bus_wdata;
            if (bus_sel && bus_wr && bus_addr == 5) m_permit = bus_wdata[0];
            m_cnt = nc; m_div = nd;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            string t;
            case (bus_addr)
                3'd0: t = "R2 csr model";
                3'd1, 3'd2: t = "R10 count model";
                3'd3, 3'd4: t = "R4 limit model";
                default: t = "R14 debug model";
            endcase
            chk(t, int'(bus_rdata), model_rdata());
            chk("R5 irq model", int'(irq), (m_flag != 0 && m_ie != 0) ? 1 : 0);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            bus_sel = 0; bus_rd = 0; bus_wr = 0;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rd = 0; bus_wr = 1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_wr = 0; bus_addr = a;
        #1 d = int'(bus_rdata);
    endtask

    task automatic set_brk(input logic v);
        @(negedge clk);
        bus_sel = 0; bus_rd = 0; bus_wr = 0; dbg_brk = v;
    endtask

    task automatic rd_count(output int v);
        int h, l;
        rd(3'd1, h);
        rd(3'd2, l);
        v = h * 256 + l;
    endtask

    task automatic irq_now(input string tag, input int exp);
        idle(1);
        #1 chk(tag, int'(irq), exp);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        int v;
        int sels[4] = '{0, 2, 5, 7};
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(3'd0, v); chk("R1 csr reset", v, 8'h20);
        rd_count(v); chk("R1 count reset", v, 0);
        rd(3'd3, v); chk("R1 limit high reset", v, 8'hFF);
        rd(3'd4, v); chk("R1 limit low reset", v, 8'hFF);
        rd(3'd5, v); chk("R1 debug reset", v, 0);
        irq_now("R1 irq reset", 0);

        // R2 clear and bit 3 read as 0
        wr(3'd0, 8'h3F);
        rd(3'd0, v); chk("R2 pad bits", v, 8'h27);
        wr(3'd0, 8'h20);

        // R3 divider: 130 enabled clocks per select value
        foreach (sels[i]) begin
            int ex;
            ex = sels[i] > 6 ? 6 : sels[i];
            wr(3'd0, 8'h10 | 8'(sels[i]));
            idle(129);
            wr(3'd0, 8'h20);
            rd_count(v); chk("R3 divided count", v, 130 >> ex);
        end

        // R7 halted counter holds
        idle(20);
        rd_count(v); chk("R7 halt freeze", v, 2);

        // R6 clear with other fields written
        wr(3'd0, 8'h73);
        rd(3'd0, v); chk("R6 fields", v, 8'h63);
        rd_count(v); chk("R6 count zero", v, 0);
        wr(3'd0, 8'h20);

        // R4 / R5 limit 5, nine advances
        wr(3'd3, 8'h00); wr(3'd4, 8'h05);
        wr(3'd0, 8'h10); idle(8); wr(3'd0, 8'h20);
        rd(3'd2, v); chk("R4 wrap at limit", v, 3);
        irq_now("R5 irq masked", 0);
        // R8 write without arm keeps flag; enable irq
        wr(3'd0, 8'h60);
        irq_now("R5 R8 irq after unarmed write", 1);
        rd(3'd0, v); chk("R8 flag seen", v, 8'hE0);
        wr(3'd0, 8'hE0);
        irq_now("R8 write of one keeps flag", 1);
        wr(3'd0, 8'h60);
        irq_now("R8 armed clear", 0);
        rd(3'd0, v); chk("R8 csr after clear", v, 8'h60);
        wr(3'd0, 8'h20);

        // R4 full 16-bit rollover
        wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
        wr(3'd0, 8'h10); idle(65534); wr(3'd0, 8'h20);
        rd_count(v); chk("R4 top count", v, 16'hFFFF);
        rd(3'd0, v); chk("R4 no flag before roll", v, 8'h20);
        wr(3'd0, 8'h00); wr(3'd0, 8'h20);
        rd(3'd2, v); chk("R4 rolled to zero", v, 0);
        rd(3'd0, v); chk("R4 flag on roll", v, 8'hA0);
        wr(3'd0, 8'h20);

        // R9 wrap every tick with limit 0
        wr(3'd3, 8'h00); wr(3'd4, 8'h00);
        wr(3'd0, 8'h10); idle(2);
        rd(3'd0, v); chk("R9 flag running", v, 8'h80);
        wr(3'd0, 8'h00); wr(3'd0, 8'h20);
        rd(3'd0, v); chk("R9 set beats clear", v, 8'hA0);
        wr(3'd0, 8'h20);

        // fresh unarmed flag with limit 2
        wr(3'd4, 8'h02);
        wr(3'd0, 8'h10); idle(3); wr(3'd0, 8'h20);

        // R11 protected halt
        set_brk(1);
        rd(3'd0, v); chk("R11 flag in halt", v, 8'hA0);
        wr(3'd0, 8'h20);
        rd(3'd0, v); chk("R11 write in halt ignored", v, 8'hA0);
        set_brk(0);
        wr(3'd0, 8'h20);
        rd(3'd0, v); chk("R11 halt read did not arm", v, 8'hA0);

        // R12 arm before halt, clear after
        set_brk(1);
        wr(3'd0, 8'h20);
        rd(3'd0, v); chk("R12 held in halt", v, 8'hA0);
        set_brk(0);
        wr(3'd0, 8'h20);
        rd(3'd0, v); chk("R12 cleared after halt", v, 8'h20);

        // R14 debug byte
        wr(3'd5, 8'hFF);
        rd(3'd5, v); chk("R14 permit only", v, 1);

        // R13 permitted clear during halt
        wr(3'd0, 8'h10); idle(3); wr(3'd0, 8'h20);
        set_brk(1);
        rd(3'd0, v); chk("R13 flag in halt", v, 8'hA0);
        wr(3'd0, 8'h20);
        set_brk(0);
        rd(3'd0, v); chk("R13 stays cleared", v, 8'h20);

        // R10 capture against a running counter
        wr(3'd5, 8'h00);
        wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
        wr(3'd0, 8'h10); idle(3);
        rd(3'd1, v); chk("R10 high byte", v, 0);
        idle(5);
        rd(3'd2, v); chk("R10 captured low", v, 3);
        rd(3'd2, v); chk("R10 live low", v, 10);
        wr(3'd0, 8'h20);
        idle(3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog R1 got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule